// File: doc/BRIEF.md
# Register-Mapped Integer Divider

This block gives a processor a 32-bit integer divider that it drives through a handful of register addresses. Software writes a dividend and a divisor. The address it writes selects the arithmetic mode. Each operand has two addresses: one treats the operands as unsigned and the other treats them as two's-complement. Both addresses of an operand reach the same storage, so the mode only records which address was written last.

Every operand write starts a fresh division. A status register reports whether the result is valid (ready) and whether the result registers have changed since software last collected the quotient (dirty). The quotient and remainder registers can also be written. This lets an interrupt handler or a thread switch save the divider's result state and later put it back. Writing either result register cancels any division in flight.

The engine is a restoring divider that retires four quotient bits per clock. A 32-bit division therefore takes eight cycles. Signed division runs on magnitudes, and the result signs are fixed up in the same cycle as the last iteration.

Top module: `div_mmio`

## Requirements
- R1: Register map on the 3-bit address: 0 unsigned dividend, 1 unsigned divisor, 2 signed dividend, 3 signed divisor, 4 quotient, 5 remainder, 6 status (bit 0 ready, bit 1 dirty, other bits zero). Address 7 reads zero. Reading either address of an operand returns the last value written through either of them.
- R2: A write to any of addresses 0 to 3 starts a new division, and restarts one already running. Ready reads 0 from the cycle after the write.
- R3: Ready reads 1 again exactly 8 cycles after the write cycle (32 bits at 4 bits per cycle). At that point the quotient and remainder hold the result.
- R4: In unsigned mode the quotient is floor(dividend / divisor) and the remainder is dividend minus quotient times divisor.
- R5: In signed mode the quotient is truncated toward zero. It is negative exactly when the operand signs differ. The remainder takes the dividend's sign.
- R6: Divide by zero takes normal time and leaves the remainder equal to the dividend. The quotient is all ones in unsigned mode. In signed mode it is -1 for a non-negative dividend and +1 for a negative one.
- R7: In signed mode, 0x80000000 divided by -1 gives a quotient of 0x80000000 and a remainder of 0.
- R8: Writing address 4 or 5 stores the written value in that result register. It cancels any running division, so the value is not overwritten later, and it sets ready and dirty.
- R9: Dirty is set by every operand write and every result-register write. It is cleared only by a read of the quotient address. Reading the remainder leaves it set. If a write and a quotient read fall in the same cycle, the set wins.
- R10: While ready is high and no write occurs, the quotient and remainder do not change.
- R11: After reset, ready is 1, dirty is 0, and the quotient, remainder and both operands read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed register, taken at the clock edge |
| rd_en | input | 1 | Read strobe; marks a read that carries a side effect (quotient read clears dirty) |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |

## Verification
The checker takes for granted that at most one register access carries a write in any cycle. It also assumes that `addr` and `wdata` are stable whenever `wr_en` is high at an edge. The bench issues every access from the falling edge, one at a time. It never raises a quotient read together with a write, so the checker's dirty-clearing property only sees a clean read. Result values are compared only once ready has returned, because their contents are meaningless while a division runs.

// File: rtl/divmm_pkg.sv
`timescale 1ns/1ps
package divmm_pkg;

  typedef enum logic [2:0] {
    ADR_U_DVD = 3'd0,
    ADR_U_DVS = 3'd1,
    ADR_S_DVD = 3'd2,
    ADR_S_DVS = 3'd3,
    ADR_QUO   = 3'd4,
    ADR_REM   = 3'd5,
    ADR_STAT  = 3'd6,
    ADR_NONE  = 3'd7
  } reg_addr_e;

  localparam int unsigned STAT_READY_BIT = 0;
  localparam int unsigned STAT_DIRTY_BIT = 1;

endpackage

// File: rtl/div_step.sv
`timescale 1ns/1ps
// Combinational slice of K restoring-division iterations.
module div_step #(
  parameter int unsigned W = 32,
  parameter int unsigned K = 4
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);

  logic [W-1:0] rem_s [K+1];
  logic [W-1:0] quo_s [K+1];

  assign rem_s[0] = rem_i;
  assign quo_s[0] = quo_i;

  for (genvar k = 0; k < K; k++) begin : g_iter
    logic [W:0] trial;
    logic [W:0] diff;
    logic       take;
    assign trial = {rem_s[k], quo_s[k][W-1]};
    assign diff  = trial - {1'b0, dvs_i};
    assign take  = ~diff[W];
    assign rem_s[k+1] = take ? diff[W-1:0] : trial[W-1:0];
    assign quo_s[k+1] = {quo_s[k][W-2:0], take};
  end

  assign rem_o = rem_s[K];
  assign quo_o = quo_s[K];

endmodule

// File: rtl/div_core.sv
`timescale 1ns/1ps
// Iterative engine: magnitude pre-conversion, STEPS iteration cycles,
// sign fix-up folded into the final cycle, result registers with direct load.
module div_core #(
  parameter int unsigned W   = 32,
  parameter int unsigned BPC = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  input  logic         ld_quo_i,
  input  logic         ld_rem_i,
  input  logic [W-1:0] ld_data_i,
  output logic         busy_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);

  localparam int unsigned STEPS = W / BPC;
  localparam int unsigned CW    = $clog2(STEPS + 1);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  remw_q, remw_d;
  logic [W-1:0]  quow_q, quow_d;
  logic [W-1:0]  dvs_q, dvs_d;
  logic          negq_q, negq_d;
  logic          negr_q, negr_d;
  logic [W-1:0]  quo_q, quo_d;
  logic [W-1:0]  rem_q, rem_d;
  logic          work_en, res_en;

  logic [W-1:0]  step_rem, step_quo;
  logic          a_neg, b_neg;
  logic [W-1:0]  a_mag, b_mag;

  div_step #(.W(W), .K(BPC)) u_step (
    .rem_i (remw_q),
    .quo_i (quow_q),
    .dvs_i (dvs_q),
    .rem_o (step_rem),
    .quo_o (step_quo)
  );

  always_comb begin
    a_neg = signed_i & dividend_i[W-1];
    b_neg = signed_i & divisor_i[W-1];
    a_mag = a_neg ? (~dividend_i + 1'b1) : dividend_i;
    b_mag = b_neg ? (~divisor_i + 1'b1) : divisor_i;
  end

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    remw_d = remw_q;
    quow_d = quow_q;
    dvs_d  = dvs_q;
    negq_d = negq_q;
    negr_d = negr_q;
    quo_d  = quo_q;
    rem_d  = rem_q;
    if (ld_quo_i) begin
      busy_d = 1'b0;
      quo_d  = ld_data_i;
    end else if (ld_rem_i) begin
      busy_d = 1'b0;
      rem_d  = ld_data_i;
    end else if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      remw_d = '0;
      quow_d = a_mag;
      dvs_d  = b_mag;
      negq_d = a_neg ^ b_neg;
      negr_d = a_neg;
    end else if (busy_q) begin
      remw_d = step_rem;
      quow_d = step_quo;
      cnt_d  = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        quo_d  = negq_q ? (~step_quo + 1'b1) : step_quo;
        rem_d  = negr_q ? (~step_rem + 1'b1) : step_rem;
      end
    end
  end

  assign work_en = start_i | busy_q;
  assign res_en  = ld_quo_i | ld_rem_i | (busy_q & (cnt_q == LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      remw_q <= '0;
      quow_q <= '0;
      dvs_q  <= '0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
      quo_q  <= '0;
      rem_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (work_en) begin
        cnt_q  <= cnt_d;
        remw_q <= remw_d;
        quow_q <= quow_d;
        dvs_q  <= dvs_d;
        negq_q <= negq_d;
        negr_q <= negr_d;
      end
      if (res_en) begin
        quo_q <= quo_d;
        rem_q <= rem_d;
      end
    end
  end

  assign busy_o = busy_q;
  assign quo_o  = quo_q;
  assign rem_o  = rem_q;

endmodule

// File: rtl/div_regs.sv
`timescale 1ns/1ps
// Address decode, shared operand storage, dirty flag and read mux.
module div_regs #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic         rd_en_i,
  input  logic [2:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         busy_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] rem_i,
  output logic         start_o,
  output logic         signed_o,
  output logic [W-1:0] dividend_o,
  output logic [W-1:0] divisor_o,
  output logic         ld_quo_o,
  output logic         ld_rem_o,
  output logic         dirty_o,
  output logic [W-1:0] rdata_o
);
  import divmm_pkg::*;

  reg_addr_e    sel;
  logic         wr_dvd, wr_dvs;
  logic [W-1:0] dvd_q, dvd_d;
  logic [W-1:0] dvs_q, dvs_d;
  logic         dirty_q, dirty_d;
  logic [W-1:0] stat;

  assign sel = reg_addr_e'(addr_i);

  always_comb begin
    wr_dvd   = wr_en_i & ((sel == ADR_U_DVD) | (sel == ADR_S_DVD));
    wr_dvs   = wr_en_i & ((sel == ADR_U_DVS) | (sel == ADR_S_DVS));
    start_o  = wr_dvd | wr_dvs;
    signed_o = wr_en_i & ((sel == ADR_S_DVD) | (sel == ADR_S_DVS));
    ld_quo_o = wr_en_i & (sel == ADR_QUO);
    ld_rem_o = wr_en_i & (sel == ADR_REM);
    dvd_d    = wr_dvd ? wdata_i : dvd_q;
    dvs_d    = wr_dvs ? wdata_i : dvs_q;
  end

  always_comb begin
    dirty_d = dirty_q;
    if (start_o | ld_quo_o | ld_rem_o) begin
      dirty_d = 1'b1;
    end else if (rd_en_i & (sel == ADR_QUO)) begin
      dirty_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q   <= '0;
      dvs_q   <= '0;
      dirty_q <= 1'b0;
    end else begin
      if (wr_dvd) dvd_q <= dvd_d;
      if (wr_dvs) dvs_q <= dvs_d;
      dirty_q <= dirty_d;
    end
  end

  always_comb begin
    stat = '0;
    stat[STAT_READY_BIT] = ~busy_i;
    stat[STAT_DIRTY_BIT] = dirty_q;
  end

  always_comb begin
    unique case (sel)
      ADR_U_DVD, ADR_S_DVD: rdata_o = dvd_q;
      ADR_U_DVS, ADR_S_DVS: rdata_o = dvs_q;
      ADR_QUO:              rdata_o = quo_i;
      ADR_REM:              rdata_o = rem_i;
      ADR_STAT:             rdata_o = stat;
      default:              rdata_o = '0;
    endcase
  end

  assign dividend_o = dvd_d;
  assign divisor_o  = dvs_d;
  assign dirty_o    = dirty_q;

endmodule

// File: rtl/div_mmio.sv
`timescale 1ns/1ps
module div_mmio #(
  parameter int unsigned DATA_W         = 32,
  parameter int unsigned BITS_PER_CYCLE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic              core_busy;
  logic              start;
  logic              st_signed;
  logic [DATA_W-1:0] dvd;
  logic [DATA_W-1:0] dvs;
  logic              ld_quo;
  logic              ld_rem;
  logic              dirty;
  logic [DATA_W-1:0] quo;
  logic [DATA_W-1:0] rem;

  div_regs #(.W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en),
    .rd_en_i    (rd_en),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .busy_i     (core_busy),
    .quo_i      (quo),
    .rem_i      (rem),
    .start_o    (start),
    .signed_o   (st_signed),
    .dividend_o (dvd),
    .divisor_o  (dvs),
    .ld_quo_o   (ld_quo),
    .ld_rem_o   (ld_rem),
    .dirty_o    (dirty),
    .rdata_o    (rdata)
  );

  div_core #(.W(DATA_W), .BPC(BITS_PER_CYCLE)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .signed_i   (st_signed),
    .dividend_i (dvd),
    .divisor_i  (dvs),
    .ld_quo_i   (ld_quo),
    .ld_rem_i   (ld_rem),
    .ld_data_i  (wdata),
    .busy_o     (core_busy),
    .quo_o      (quo),
    .rem_o      (rem)
  );

endmodule

// File: rtl/div_mmio_chk.sv
`timescale 1ns/1ps
module div_mmio_chk #(
  parameter int unsigned W     = 32,
  parameter int unsigned STEPS = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic         rd_en,
  input logic [2:0]   addr,
  input logic [W-1:0] wdata,
  input logic         busy,
  input logic         dirty,
  input logic [W-1:0] quo,
  input logic [W-1:0] rem
);

  localparam int unsigned RW = $clog2(STEPS + 2) + 1;

  logic          op_wr;
  logic          res_wr;
  logic [RW-1:0] run_cnt;

  assign op_wr  = wr_en && (addr < 3'd4);
  assign res_wr = wr_en && ((addr == 3'd4) || (addr == 3'd5));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (op_wr) begin
      run_cnt <= RW'(1);
    end else if (busy) begin
      run_cnt <= run_cnt + 1'b1;
    end else begin
      run_cnt <= '0;
    end
  end

  p_start_drops_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_wr |=> busy);

  p_ready_in_time_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_cnt <= RW'(STEPS)));

  p_direct_load_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr |=> (!busy && dirty));

  p_direct_load_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == 3'd4)) |=> (quo == $past(wdata)));

  p_quo_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && (addr == 3'd4)) |=> !dirty);

  p_write_sets_dirty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wr || res_wr) |=> dirty);

  p_results_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_en) |=> ($stable(quo) && $stable(rem)));

endmodule

bind div_mmio div_mmio_chk #(
  .W     (DATA_W),
  .STEPS (DATA_W / BITS_PER_CYCLE)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .wr_en (wr_en),
  .rd_en (rd_en),
  .addr  (addr),
  .wdata (wdata),
  .busy  (core_busy),
  .dirty (dirty),
  .quo   (quo),
  .rem   (rem)
);

// File: tb/tb_div_mmio.sv
`timescale 1ns/1ps
module tb_div_mmio;

  localparam logic [2:0] A_UDVD = 3'd0, A_UDVS = 3'd1, A_SDVD = 3'd2,
                         A_SDVS = 3'd3, A_QUO = 3'd4, A_REM = 3'd5, A_STAT = 3'd6;

  // {tag(4), signed(1), dividend, divisor, quotient, remainder}
  localparam int NV = 13;
  localparam logic [132:0] VEC [NV] = '{
    {4'd4, 1'b0, 32'd100,        32'd7,          32'd14,         32'd2},
    {4'd4, 1'b0, 32'hFFFFFFFF,   32'd1,          32'hFFFFFFFF,   32'd0},
    {4'd4, 1'b0, 32'hFFFFFFFF,   32'h10,         32'h0FFFFFFF,   32'hF},
    {4'd4, 1'b0, 32'd5,          32'd9,          32'd0,          32'd5},
    {4'd4, 1'b0, 32'h80000000,   32'hFFFFFFFF,   32'd0,          32'h80000000},
    {4'd4, 1'b0, 32'd1000000,    32'd1000,       32'd1000,       32'd0},
    {4'd5, 1'b1, 32'hFFFFFFF9,   32'd2,          32'hFFFFFFFD,   32'hFFFFFFFF},
    {4'd5, 1'b1, 32'd7,          32'hFFFFFFFE,   32'hFFFFFFFD,   32'd1},
    {4'd5, 1'b1, 32'hFFFFFFF9,   32'hFFFFFFFE,   32'd3,          32'hFFFFFFFF},
    {4'd7, 1'b1, 32'h80000000,   32'hFFFFFFFF,   32'h80000000,   32'd0},
    {4'd6, 1'b0, 32'd12345,      32'd0,          32'hFFFFFFFF,   32'd12345},
    {4'd6, 1'b1, 32'hFFFFFFF6,   32'd0,          32'd1,          32'hFFFFFFF6},
    {4'd6, 1'b1, 32'd10,         32'd0,          32'hFFFFFFFF,   32'd10}
  };

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        rd_en;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;

  int checks;
  int errors;

  div_mmio dut (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    addr  = a;
    wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    addr  = a;
    rd_en = 1'b1;
    #1;
    v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] q_keep;
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    wr_en = 1'b0;
    rd_en = 1'b0;
    addr  = 3'd0;
    wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    peek(A_STAT, v); check("R11 status", v, 32'h1);
    peek(A_QUO, v);  check("R11 quotient", v, 32'h0);
    peek(A_REM, v);  check("R11 remainder", v, 32'h0);
    peek(A_UDVD, v); check("R11 dividend", v, 32'h0);

    // vector table: R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [3:0]  t;
      logic        sg;
      logic [31:0] a, b, eq, er;
      {t, sg, a, b, eq, er} = VEC[i];
      wr(sg ? A_SDVD : A_UDVD, a);
      wr(sg ? A_SDVS : A_UDVS, b);
      repeat (8) @(negedge clk);
      peek(A_STAT, v); check("R3 ready after 8", {31'd0, v[0]}, 32'd1);
      rd(A_REM, v); check({tag_name(t), " remainder"}, v, er);
      rd(A_QUO, v); check({tag_name(t), " quotient"}, v, eq);
    end

    // R1 aliases share storage, address 7 reads zero
    wr(A_SDVD, 32'h1234);
    peek(A_UDVD, v); check("R1 dividend alias", v, 32'h1234);
    wr(A_UDVS, 32'd5);
    peek(A_SDVS, v); check("R1 divisor alias", v, 32'd5);
    peek(3'd7, v); check("R1 unused address", v, 32'd0);
    repeat (8) @(negedge clk);

    // R2 / R3 ready timing
    wr(A_UDVD, 32'd99);
    peek(A_STAT, v); check("R2 ready low after start", {31'd0, v[0]}, 32'd0);
    repeat (7) @(negedge clk);
    peek(A_STAT, v); check("R3 ready low at 7", {31'd0, v[0]}, 32'd0);
    @(negedge clk);
    peek(A_STAT, v); check("R3 ready high at 8", {31'd0, v[0]}, 32'd1);

    // R9 dirty handling, R10 hold
    peek(A_STAT, v); check("R9 dirty after start", {31'd0, v[1]}, 32'd1);
    rd(A_REM, v);    check("R4 99/5 remainder", v, 32'd4);
    peek(A_STAT, v); check("R9 remainder read keeps dirty", {31'd0, v[1]}, 32'd1);
    rd(A_QUO, v);    check("R4 99/5 quotient", v, 32'd19);
    peek(A_STAT, v); check("R9 quotient read clears dirty", {31'd0, v[1]}, 32'd0);
    repeat (5) @(negedge clk);
    peek(A_QUO, v);  check("R10 quotient held", v, 32'd19);
    peek(A_REM, v);  check("R10 remainder held", v, 32'd4);

    // R8 direct result write aborts a running division
    wr(A_UDVS, 32'd3);
    repeat (2) @(negedge clk);
    wr(A_QUO, 32'hDEADBEEF);
    peek(A_STAT, v); check("R8 ready and dirty after load", v, 32'h3);
    repeat (10) @(negedge clk);
    peek(A_QUO, v);  check("R8 quotient not overwritten", v, 32'hDEADBEEF);
    q_keep = v;
    wr(A_REM, 32'h0BADF00D);
    peek(A_REM, v);  check("R8 remainder load", v, 32'h0BADF00D);
    peek(A_QUO, v);  check("R10 quotient kept across remainder load", v, q_keep);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule